// File: doc/BRIEF.md
# Watermark-Windowed Flash Data FIFO Pair

This block sits between a 32-bit register bus and a serial flash sequencer and buffers flash data in both directions. Each direction is a FIFO of 64-bit entries. Software never pushes or pops single words. It sees a window of two 32-bit data registers that together make up one 8-byte entry, which is the watermark. It fills or drains that window and then writes 1 to a status bit to commit the window.

On the transmit side the sequencer pulls bytes out of the head entry, lowest byte first. On the receive side it delivers bytes that are packed into entries, lowest byte first. A sequence-end pulse closes a partial entry in either direction. The block reports the window flags, the fill levels, running commit and advance counters and sticky error flags. A per-FIFO clear control empties a FIFO in one write.

Top module: `wmwin_ip_fifo`

## Requirements
- R1: After reset both FIFOs are empty. The flag register (word address 4) reads 0x1: bit 0, TX window free, is set and bits 1 to 3 are clear. Both status registers (addresses 6 and 7) read 0, `tx_valid` is low and `rx_ready` is high.
- R2: Software writes the TX window low word (address 2) and high word (address 3), then writes 1 to flag bit 0. That write appends the entry {high, low} to the TX FIFO. The TX status register (address 6) holds the fill level in bits [15:0] and a successful-commit counter in bits [31:16]. The sequencer stream sends the head entry bytes 0 to 7 in order, where byte k is entry bits [8k+7:8k].
- R3: A pulse on `seq_end` while a TX entry is partly sent drops the rest of that entry. The next byte offered is byte 0 of the following entry, so a partial window needs only its low word written.
- R4: Flag bit 0 reads 1 exactly when the TX FIFO is not full. A commit on a full TX FIFO leaves the fill level and commit counter unchanged and sets the sticky overflow flag (flag bit 2). Writing 1 to flag bit 2 clears that flag.
- R5: The received bytes fill an entry from byte 0 upward. Once 8 bytes have arrived the entry is appended to the RX FIFO. Flag bit 1 reads 1 whenever the RX FIFO holds at least one entry. The head entry reads at address 0 (bits [31:0]) and address 1 (bits [63:32]).
- R6: Writing 1 to flag bit 1 removes the RX head entry. The RX status register (address 7) holds the fill level in bits [15:0] and a successful-advance counter in bits [31:16].
- R7: A pulse on `seq_end` while 1 to 7 bytes of an RX entry have arrived appends that entry with its missing upper bytes set to zero. Flag bit 1 then reports the data as available.
- R8: An advance on an empty RX FIFO leaves the fill level and advance counter unchanged and sets the sticky underflow flag (flag bit 3). Writing 1 to flag bit 3 clears that flag.
- R9: Writing 1 to bit 0 of the control register (address 5) empties the TX FIFO. Writing 1 to bit 1 empties the RX FIFO. Either write also zeroes that FIFO's counter and any partly assembled or partly sent entry. The control register reads 0 afterwards.
- R10: `rx_ready` is low while the RX FIFO is full. A byte offered while `rx_ready` is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_valid | output | 1 | A transmit byte is offered to the sequencer |
| tx_ready | input | 1 | Sequencer takes the offered transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Sequencer offers a received byte |
| rx_ready | output | 1 | Block can take a received byte |
| rx_data | input | 8 | Received byte |
| seq_end | input | 1 | Sequence-end pulse that closes partial entries |

## Verification
The hardest conditions to reach are the two boundaries. The first is the TX FIFO completely full while another commit arrives. The second is the RX FIFO full while the sequencer still offers a byte. The bench reaches the first with 128 back-to-back commits while `tx_ready` is held low. It reaches the second by streaming 512 bytes with no advances. It then offers one more byte, clears the FIFO and checks that the next window holds only fresh data. The partial-entry cases are also timing-sensitive. For these the bench releases exactly four TX bytes before pulsing `seq_end`, and flushes a three-byte RX remainder the same way.

// File: rtl/ipwin_pkg.sv
package ipwin_pkg;
    localparam int WORD_W   = 32;
    localparam int ENTRY_W  = 2 * WORD_W;
    localparam int ENTRY_B  = ENTRY_W / 8;
    localparam int BIDX_W   = $clog2(ENTRY_B);
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_RXWIN_LO = 3'd0,
        A_RXWIN_HI = 3'd1,
        A_TXWIN_LO = 3'd2,
        A_TXWIN_HI = 3'd3,
        A_FLAGS    = 3'd4,
        A_CTRL     = 3'd5,
        A_TXSTS    = 3'd6,
        A_RXSTS    = 3'd7
    } reg_addr_e;

    localparam int F_TXFREE = 0;
    localparam int F_RXAVL  = 1;
    localparam int F_TXOVF  = 2;
    localparam int F_RXUNF  = 3;
    localparam int C_TXCLR  = 0;
    localparam int C_RXCLR  = 1;
endpackage

// File: rtl/ipwin_fifo_core.sv
module ipwin_fifo_core #(
    parameter int DEPTH = 64,
    parameter int W     = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (st_q.count == CW'(DEPTH));
    assign empty   = (st_q.count == '0);
    assign count   = st_q.count;
    assign head    = mem[st_q.rptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push)
                st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
            if (do_pop)
                st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear) mem[st_q.wptr] <= push_data;
    end

    // R4
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> $stable(count));
    // R8
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clear) |=> (count == '0));
    // R9
    fifo_clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/ipwin_tx_unpack.sv
module ipwin_tx_unpack
    import ipwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               avail,
    input  logic               byte_ready,
    input  logic               seq_end,
    output logic               byte_valid,
    output logic [7:0]         byte_data,
    output logic               pop
);
    typedef struct packed {
        logic [BIDX_W-1:0] idx;
    } unp_st_t;

    unp_st_t st_d, st_q;
    logic take;
    logic [BIDX_W-1:0] nidx;

    assign byte_valid = avail;
    assign byte_data  = entry[{st_q.idx, 3'b000} +: 8];
    assign take       = avail && byte_ready;

    always_comb begin
        st_d = st_q;
        nidx = take ? st_q.idx + 1'b1 : st_q.idx;
        pop  = 1'b0;
        if (take && (st_q.idx == BIDX_W'(ENTRY_B - 1)))
            pop = 1'b1;
        if (seq_end && (nidx != '0))
            pop = 1'b1;
        st_d.idx = seq_end ? '0 : nidx;
        if (clear) begin
            st_d = '0;
            pop  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    unp_seq_end_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |=> (st_q.idx == '0));
endmodule

// File: rtl/ipwin_rx_pack.sv
module ipwin_rx_pack
    import ipwin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               byte_valid,
    input  logic [7:0]         byte_data,
    input  logic               room,
    input  logic               seq_end,
    output logic               byte_ready,
    output logic               push,
    output logic [ENTRY_W-1:0] push_data
);
    typedef struct packed {
        logic [ENTRY_W-1:0] acc;
        logic [BIDX_W-1:0]  idx;
    } pk_st_t;

    pk_st_t st_d, st_q;
    logic take;
    logic [BIDX_W-1:0] nidx;
    logic [ENTRY_W-1:0] nacc;

    assign byte_ready = room;
    assign take       = byte_valid && room;

    always_comb begin
        st_d = st_q;
        nacc = st_q.acc;
        nidx = st_q.idx;
        if (take) begin
            nacc[{st_q.idx, 3'b000} +: 8] = byte_data;
            nidx = st_q.idx + 1'b1;
        end
        push = (take && (st_q.idx == BIDX_W'(ENTRY_B - 1)))
            || (seq_end && (nidx != '0));
        push_data = nacc;
        st_d.acc  = push ? '0 : nacc;
        st_d.idx  = push ? '0 : nidx;
        if (clear) begin
            st_d = '0;
            push = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    pk_refused_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready && !seq_end && !clear) |=> $stable(st_q.idx));
    // R7
    pk_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && !clear) |=> (st_q.idx == '0));
endmodule

// File: rtl/wmwin_ip_fifo.sv
module wmwin_ip_fifo
    import ipwin_pkg::*;
#(
    parameter int TX_DEPTH = 128,
    parameter int RX_DEPTH = 64,
    localparam int TX_CW   = $clog2(TX_DEPTH) + 1,
    localparam int RX_CW   = $clog2(RX_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              seq_end
);
    typedef struct packed {
        logic [WORD_W-1:0] tx_lo;
        logic [WORD_W-1:0] tx_hi;
        logic              tx_ovf;
        logic              rx_unf;
        logic [CNT_W-1:0]  tx_wcnt;
        logic [CNT_W-1:0]  rx_rcnt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic wr_flags, commit, advance, tx_clr, rx_clr;
    logic tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
    logic [ENTRY_W-1:0] tx_head, rx_head, rx_pdata;
    logic [TX_CW-1:0] tx_count;
    logic [RX_CW-1:0] rx_count;

    assign wr_flags = reg_wr && (reg_addr == A_FLAGS);
    assign commit   = wr_flags && reg_wdata[F_TXFREE];
    assign advance  = wr_flags && reg_wdata[F_RXAVL];
    assign tx_clr   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[C_TXCLR];
    assign rx_clr   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[C_RXCLR];

    ipwin_fifo_core #(.DEPTH(TX_DEPTH), .W(ENTRY_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clear(tx_clr),
        .push(commit), .push_data({st_q.tx_hi, st_q.tx_lo}),
        .pop(tx_pop), .head(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    ipwin_tx_unpack u_tx_unpack (
        .clk(clk), .rst_n(rst_n), .clear(tx_clr),
        .entry(tx_head), .avail(!tx_empty), .byte_ready(tx_ready),
        .seq_end(seq_end), .byte_valid(tx_valid), .byte_data(tx_data),
        .pop(tx_pop)
    );

    ipwin_fifo_core #(.DEPTH(RX_DEPTH), .W(ENTRY_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clear(rx_clr),
        .push(rx_push), .push_data(rx_pdata),
        .pop(advance), .head(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    ipwin_rx_pack u_rx_pack (
        .clk(clk), .rst_n(rst_n), .clear(rx_clr),
        .byte_valid(rx_valid), .byte_data(rx_data), .room(!rx_full),
        .seq_end(seq_end), .byte_ready(rx_ready),
        .push(rx_push), .push_data(rx_pdata)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr && (reg_addr == A_TXWIN_LO)) st_d.tx_lo = reg_wdata;
        if (reg_wr && (reg_addr == A_TXWIN_HI)) st_d.tx_hi = reg_wdata;

        if (wr_flags && reg_wdata[F_TXOVF]) st_d.tx_ovf = 1'b0;
        if (commit && tx_full)              st_d.tx_ovf = 1'b1;
        if (wr_flags && reg_wdata[F_RXUNF]) st_d.rx_unf = 1'b0;
        if (advance && rx_empty)            st_d.rx_unf = 1'b1;

        if (tx_clr)                   st_d.tx_wcnt = '0;
        else if (commit && !tx_full)  st_d.tx_wcnt = st_q.tx_wcnt + 1'b1;
        if (rx_clr)                   st_d.rx_rcnt = '0;
        else if (advance && !rx_empty) st_d.rx_rcnt = st_q.rx_rcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RXWIN_LO: reg_rdata = rx_head[WORD_W-1:0];
            A_RXWIN_HI: reg_rdata = rx_head[ENTRY_W-1:WORD_W];
            A_TXWIN_LO: reg_rdata = st_q.tx_lo;
            A_TXWIN_HI: reg_rdata = st_q.tx_hi;
            A_FLAGS: begin
                reg_rdata[F_TXFREE] = !tx_full;
                reg_rdata[F_RXAVL]  = !rx_empty;
                reg_rdata[F_TXOVF]  = st_q.tx_ovf;
                reg_rdata[F_RXUNF]  = st_q.rx_unf;
            end
            A_TXSTS: reg_rdata = {st_q.tx_wcnt, CNT_W'(tx_count)};
            A_RXSTS: reg_rdata = {st_q.rx_rcnt, CNT_W'(rx_count)};
            default: reg_rdata = '0;
        endcase
    end

    // R4
    tx_ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && tx_full) |=> st_q.tx_ovf);
    // R8
    rx_unf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && rx_empty) |=> st_q.rx_unf);
    // R2
    tx_commit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !tx_full && !tx_pop) |=> (tx_count == $past(tx_count) + 1'b1));
    // R6
    rx_advance_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !rx_empty && !rx_push && !rx_clr) |=> (rx_count == $past(rx_count) - 1'b1));
endmodule

// File: tb/tb_wmwin_ip_fifo.sv
`timescale 1ns/1ps
module tb_wmwin_ip_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        seq_end = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] txq [$];
    logic [7:0] rxq [$];

    always #5 clk = ~clk;

    wmwin_ip_fifo dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .seq_end(seq_end)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(string tag, logic [2:0] a, logic [31:0] exp);
        logic [31:0] v;
        reg_read(a, v);
        check(tag, v, exp);
    endtask

    // Driver: stage a window, commit it, queue the bytes the stream must carry.
    task automatic tx_push_entry(logic [63:0] e, int nbytes, bit write_hi);
        reg_write(3'd2, e[31:0]);
        if (write_hi) reg_write(3'd3, e[63:32]);
        reg_write(3'd4, 32'h1);
        for (int k = 0; k < nbytes; k++) txq.push_back(e[8*k +: 8]);
    endtask

    task automatic tx_drain();
        @(negedge clk);
        tx_ready = 1'b1;
        while (txq.size() != 0) begin
            @(posedge clk); #1;
        end
        tx_ready = 1'b0;
    endtask

    task automatic tx_take(int k);
        @(negedge clk);
        tx_ready = 1'b1;
        repeat (k) @(posedge clk);
        #1 tx_ready = 1'b0;
    endtask

    task automatic pulse_seq_end();
        @(negedge clk);
        seq_end = 1'b1;
        @(posedge clk); #1;
        seq_end = 1'b0;
    endtask

    task automatic rx_send(logic [7:0] b, bit record);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        if (record) rxq.push_back(b);
    endtask

    // Reader side of the RX scoreboard: compare the window against queued bytes.
    task automatic rx_check_window(string tag);
        logic [31:0] lo, hi;
        logic [63:0] e;
        reg_read(3'd0, lo);
        reg_read(3'd1, hi);
        e = {hi, lo};
        for (int k = 0; k < 8; k++) begin
            logic [7:0] exp_b;
            exp_b = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
            check(tag, {24'h0, e[8*k +: 8]}, {24'h0, exp_b});
        end
    endtask

    // Monitor: every byte handed to the sequencer is compared in order (R2, R3).
    initial begin
        forever begin
            @(negedge clk); #1;
            if (tx_valid && tx_ready) begin
                n_chk++;
                if (txq.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2 R3 stream: actual %h expected none", tx_data);
                end else begin
                    logic [7:0] exp_b;
                    exp_b = txq.pop_front();
                    if (tx_data !== exp_b) begin
                        n_bad++;
                        $display("FAIL R2 R3 stream: actual %h expected %h", tx_data, exp_b);
                    end
                end
            end
        end
    end

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg("R1 flags", 3'd4, 32'h1);
        expect_reg("R1 txsts", 3'd6, 32'h0);
        expect_reg("R1 rxsts", 3'd7, 32'h0);
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        check("R1 rx_ready", {31'h0, rx_ready}, 32'h1);

        // R2 commit two windows, stream them out in byte order
        tx_push_entry(64'h8877665544332211, 8, 1'b1);
        expect_reg("R2 txsts one", 3'd6, {16'd1, 16'd1});
        tx_push_entry(64'hF0E1D2C3B4A59687, 8, 1'b1);
        expect_reg("R2 txsts two", 3'd6, {16'd2, 16'd2});
        tx_drain();
        expect_reg("R2 txsts drained", 3'd6, {16'd2, 16'd0});

        // R3 partial window: low word only, four bytes then sequence end
        tx_push_entry(64'h0000000013579BDF, 4, 1'b0);
        tx_push_entry(64'hCAFEBABE0BADF00D, 8, 1'b1);
        tx_take(4);
        pulse_seq_end();
        tx_drain();
        expect_reg("R3 txsts after", 3'd6, {16'd4, 16'd0});
        check("R3 queue empty", txq.size(), 0);

        // R4 fill TX, commit once more
        for (int i = 0; i < 128; i++) reg_write(3'd4, 32'h1);
        expect_reg("R4 txsts full", 3'd6, {16'd132, 16'd128});
        expect_reg("R4 flags full", 3'd4, 32'h0);
        reg_write(3'd4, 32'h1);
        expect_reg("R4 txsts unchanged", 3'd6, {16'd132, 16'd128});
        expect_reg("R4 flags ovf", 3'd4, 32'h4);
        reg_write(3'd4, 32'h4);
        expect_reg("R4 ovf cleared", 3'd4, 32'h0);

        // R9 TX clear
        reg_write(3'd5, 32'h1);
        expect_reg("R9 txsts cleared", 3'd6, 32'h0);
        expect_reg("R9 flags after tx clear", 3'd4, 32'h1);
        expect_reg("R9 ctrl self-clears", 3'd5, 32'h0);
        check("R9 tx_valid low", {31'h0, tx_valid}, 32'h0);

        // R5 pack eight bytes into one RX entry
        for (int i = 0; i < 8; i++) rx_send(8'h10 + 8'(i), 1'b1);
        expect_reg("R5 flags avail", 3'd4, 32'h3);
        expect_reg("R5 rxsts", 3'd7, {16'd0, 16'd1});
        rx_check_window("R5 window");

        // R6 advance
        reg_write(3'd4, 32'h2);
        expect_reg("R6 rxsts", 3'd7, {16'd1, 16'd0});
        expect_reg("R6 flags", 3'd4, 32'h1);

        // R7 partial flush
        rx_send(8'hA1, 1'b1);
        rx_send(8'hB2, 1'b1);
        rx_send(8'hC3, 1'b1);
        expect_reg("R7 not yet", 3'd7, {16'd1, 16'd0});
        pulse_seq_end();
        expect_reg("R7 flags avail", 3'd4, 32'h3);
        rx_check_window("R7 window");
        reg_write(3'd4, 32'h2);

        // R8 advance on empty
        reg_write(3'd4, 32'h2);
        expect_reg("R8 rxsts unchanged", 3'd7, {16'd2, 16'd0});
        expect_reg("R8 flags unf", 3'd4, 32'h9);
        reg_write(3'd4, 32'h8);
        expect_reg("R8 unf cleared", 3'd4, 32'h1);

        // R10 fill RX completely, offer a byte while full
        for (int i = 0; i < 512; i++) rx_send(8'(i), 1'b0);
        expect_reg("R10 rxsts full", 3'd7, {16'd2, 16'd64});
        check("R10 rx_ready low", {31'h0, rx_ready}, 32'h0);
        rx_send(8'hEE, 1'b0);
        expect_reg("R10 still full", 3'd7, {16'd2, 16'd64});

        // R9 RX clear, then fresh data must be the whole window
        reg_write(3'd5, 32'h2);
        expect_reg("R9 rxsts cleared", 3'd7, 32'h0);
        check("R9 rx_ready back", {31'h0, rx_ready}, 32'h1);
        for (int i = 0; i < 8; i++) rx_send(8'h50 + 8'(i), 1'b1);
        rx_check_window("R10 R9 fresh window");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule